// File: doc/BRIEF.md
# Cell Transmit Ingress with Odd-Parity Check

This block is the receiving end, inside a physical-layer device, of an 8-bit byte-wide cell bus on which an upstream cell-switching device hands over fixed 53-byte cells for transmission. It runs on a free-running clock. A byte is taken on every edge where the sender holds the active-low enable input low. The start-of-cell flag marks the first byte of each cell. Bytes are gathered into a slot of a small cell store. A slot becomes visible to the drain side only after all 53 bytes have arrived. The drain side then reads the cell out one byte per cycle under a valid/ready handshake.

The block tells the sender when a whole free slot exists. Every accepted byte is checked for odd parity over the eight data bits plus the parity bit. A failed check never alters or drops data. When checking is switched on, a failure only raises a sticky status bit. A second sticky bit records a cell cut short by an early start-of-cell. Each status bit is cleared by writing 1 to it. A single interrupt output combines the status bits that are enabled by a mask.

Top module: `cell_tx_ingress`

## Requirements
- R1: `cellRoom` is 1 while fewer than DEPTH_CELLS cells are held, and 0 otherwise. A cell is held from the edge that stores its 53rd byte until the edge that drains its last byte.
- R2: A byte is accepted only on an edge where `busEnN` is 0. A byte that is not inside a cell is ignored: one that arrives with `busEnN` high, or one that arrives without `busSoc` while no cell is being gathered.
- R3: A cell reaches the drain side (`outValid` = 1) only after all 53 of its bytes are stored, starting with the edge that accepts the 53rd byte. Any byte after that, up to the next `busSoc`, is ignored.
- R4: With `parChkEn` = 1, an accepted byte whose eight data bits plus `busPar` hold an even number of ones sets `sts[0]`.
- R5: With `parChkEn` = 0, parity is never recorded. Data is stored and drained unchanged whatever its parity.
- R6: `sts` bits are sticky. A 1 on `stsClr[k]` clears `sts[k]` at the next edge. A set in the same cycle wins over the clear.
- R7: `irq` equals the OR over k of `sts[k] & irqEn[k]`, with no added delay.
- R8: A `busSoc` that arrives while a cell is only partly gathered drops the partial cell and sets `sts[1]`. That same byte becomes byte 0 of a new cell.
- R9: Cells are drained in arrival order with their bytes in order. `outSoc` is 1 with byte 0 of each cell. One byte leaves on each edge where `outValid` and `popReady` are both 1.
- R10: A cell whose start-of-cell byte arrives while `cellRoom` is 0 is discarded as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busData | input | 8 | Incoming cell byte |
| busPar | input | 1 | Odd parity bit for busData |
| busSoc | input | 1 | Marks the first byte of a cell |
| busEnN | input | 1 | Sender drives a byte, active low |
| cellRoom | output | 1 | A full free cell slot exists |
| parChkEn | input | 1 | Enables recording of parity errors |
| irqEn | input | 2 | Interrupt mask per status bit |
| stsClr | input | 2 | Write-1-to-clear strobe per status bit |
| sts | output | 2 | Sticky status: bit0 parity error, bit1 runt cell |
| irq | output | 1 | OR of the enabled status bits |
| popReady | input | 1 | Drain side takes a byte |
| outValid | output | 1 | A stored byte is on outData |
| outData | output | 8 | Drained cell byte |
| outSoc | output | 1 | outData is byte 0 of a cell |

## Verification
Every result comes from a register, so each one is due one edge after the input that causes it. This covers status setting and clearing, the drain pointer advancing, the 53rd byte making a cell visible, and `cellRoom` falling or rising. The only exception is `irq`, which follows `irqEn` combinationally within the same cycle. The bench drives inputs on the falling edge. It compares every output on the following falling edge, against a reference queue that is updated as though the intervening rising edge has applied those inputs. Each comparison therefore lands exactly one register stage after its stimulus.

// File: rtl/cti_pkg.sv
package cti_pkg;
  localparam int CELL_BYTES = 53;
  localparam int IDX_W      = $clog2(CELL_BYTES);
  localparam int STS_BITS   = 2;
  localparam int STS_PAR    = 0;
  localparam int STS_RUNT   = 1;

  // strobes from the capture control to the cell store
  typedef struct packed {
    logic             wrEn;
    logic             commit;
    logic [IDX_W-1:0] wrIdx;
  } capStrobe_t;
endpackage

// File: rtl/cti_ctrl.sv
module cti_ctrl
  import cti_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          busData,
  input  logic                busPar,
  input  logic                busSoc,
  input  logic                busEnN,
  input  logic                roomAvail,
  input  logic                parChkEn,
  input  logic [STS_BITS-1:0] irqEn,
  input  logic [STS_BITS-1:0] stsClr,
  output capStrobe_t          strobe,
  output logic [STS_BITS-1:0] sts,
  output logic                irq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic             capturing;
  logic [IDX_W-1:0] byteCnt;
  logic             accept;
  logic             startNow;
  logic             parBad;
  logic             runtNow;
  logic [STS_BITS-1:0] setVec;

  always_comb begin
    accept   = !busEnN;
    startNow = accept && busSoc;
    // odd parity: data bits plus parity bit must hold an odd count of ones
    parBad   = accept && parChkEn && !(^{busData, busPar});
    runtNow  = startNow && capturing;
    setVec           = '0;
    setVec[STS_PAR]  = parBad;
    setVec[STS_RUNT] = runtNow;
  end

  always_comb begin
    strobe.wrEn   = accept && (busSoc ? roomAvail : capturing);
    strobe.wrIdx  = busSoc ? '0 : byteCnt;
    strobe.commit = accept && !busSoc && capturing && (byteCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capturing <= 1'b0;
      byteCnt   <= '0;
    end else if (startNow) begin
      capturing <= roomAvail;
      byteCnt   <= IDX_W'(1);
    end else if (accept && capturing) begin
      if (byteCnt == LAST_IDX) begin
        capturing <= 1'b0;
        byteCnt   <= '0;
      end else begin
        byteCnt <= byteCnt + IDX_W'(1);
      end
    end
  end

  for (genvar g = 0; g < STS_BITS; g++) begin : g_sts
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sts[g] <= 1'b0;
      else       sts[g] <= setVec[g] | (sts[g] & !stsClr[g]);
    end
  end

  assign irq = |(sts & irqEn);
endmodule

// File: rtl/cti_datapath.sv
module cti_datapath
  import cti_pkg::*;
#(
  parameter int DEPTH_CELLS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  capStrobe_t strobe,
  input  logic [7:0] busData,
  input  logic       popReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outSoc,
  output logic       roomAvail
);
  localparam int MEM_BYTES = DEPTH_CELLS * CELL_BYTES;
  localparam int ADDR_W    = $clog2(MEM_BYTES);
  localparam int SLOT_W    = (DEPTH_CELLS > 1) ? $clog2(DEPTH_CELLS) : 1;
  localparam int USED_W    = $clog2(DEPTH_CELLS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [7:0]        cellMem [MEM_BYTES];
  logic [SLOT_W-1:0] wrSlot;
  logic [SLOT_W-1:0] rdSlot;
  logic [IDX_W-1:0]  rdIdx;
  logic [USED_W-1:0] usedCells;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic              popNow;
  logic              lastPop;

  function automatic logic [SLOT_W-1:0] slotNext(input logic [SLOT_W-1:0] s);
    return (int'(s) == DEPTH_CELLS - 1) ? '0 : s + SLOT_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] byteAddr(input logic [SLOT_W-1:0] s,
                                                 input logic [IDX_W-1:0] i);
    return ADDR_W'(int'(s) * CELL_BYTES + int'(i));
  endfunction

  always_comb begin
    wrAddr    = byteAddr(wrSlot, strobe.wrIdx);
    rdAddr    = byteAddr(rdSlot, rdIdx);
    outValid  = (usedCells != '0);
    outData   = cellMem[rdAddr];
    outSoc    = (rdIdx == '0);
    roomAvail = (usedCells < USED_W'(DEPTH_CELLS));
    popNow    = outValid && popReady;
    lastPop   = popNow && (rdIdx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) cellMem[wrAddr] <= busData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSlot    <= '0;
      rdSlot    <= '0;
      rdIdx     <= '0;
      usedCells <= '0;
    end else begin
      if (strobe.commit) wrSlot <= slotNext(wrSlot);
      if (popNow) begin
        if (lastPop) begin
          rdIdx  <= '0;
          rdSlot <= slotNext(rdSlot);
        end else begin
          rdIdx <= rdIdx + IDX_W'(1);
        end
      end
      case ({strobe.commit, lastPop})
        2'b10:   usedCells <= usedCells + USED_W'(1);
        2'b01:   usedCells <= usedCells - USED_W'(1);
        default: usedCells <= usedCells;
      endcase
    end
  end
endmodule

// File: rtl/cell_tx_ingress.sv
module cell_tx_ingress
  import cti_pkg::*;
#(
  parameter int DEPTH_CELLS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busData,
  input  logic       busPar,
  input  logic       busSoc,
  input  logic       busEnN,
  output logic       cellRoom,
  input  logic       parChkEn,
  input  logic [1:0] irqEn,
  input  logic [1:0] stsClr,
  output logic [1:0] sts,
  output logic       irq,
  input  logic       popReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outSoc
);
  capStrobe_t strobe;

  cti_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busData   (busData),
    .busPar    (busPar),
    .busSoc    (busSoc),
    .busEnN    (busEnN),
    .roomAvail (cellRoom),
    .parChkEn  (parChkEn),
    .irqEn     (irqEn),
    .stsClr    (stsClr),
    .strobe    (strobe),
    .sts       (sts),
    .irq       (irq)
  );

  cti_datapath #(.DEPTH_CELLS(DEPTH_CELLS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busData   (busData),
    .popReady  (popReady),
    .outValid  (outValid),
    .outData   (outData),
    .outSoc    (outSoc),
    .roomAvail (cellRoom)
  );
endmodule

// File: rtl/cti_checker.sv
module cti_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busData,
  input logic       busPar,
  input logic       busSoc,
  input logic       busEnN,
  input logic       cellRoom,
  input logic       parChkEn,
  input logic [1:0] irqEn,
  input logic [1:0] stsClr,
  input logic [1:0] sts,
  input logic       irq,
  input logic       outValid
);
  p_full_has_data_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cellRoom |-> outValid);

  p_par_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sts[0]) |-> $past(!busEnN && parChkEn && !(^{busData, busPar})));

  p_par_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!parChkEn && !sts[0]) |=> !sts[0]);

  p_sticky_par_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sts[0] && !stsClr[0]) |=> sts[0]);

  p_sticky_runt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sts[1] && !stsClr[1]) |=> sts[1]);

  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == 2'b00) |-> !irq);

  p_runt_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sts[1]) |-> $past(!busEnN && busSoc));
endmodule

bind cell_tx_ingress cti_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busData  (busData),
  .busPar   (busPar),
  .busSoc   (busSoc),
  .busEnN   (busEnN),
  .cellRoom (cellRoom),
  .parChkEn (parChkEn),
  .irqEn    (irqEn),
  .stsClr   (stsClr),
  .sts      (sts),
  .irq      (irq),
  .outValid (outValid)
);

// File: tb/sim_cell_tx_ingress.sv
`timescale 1ns/1ps
module sim_cell_tx_ingress;
  localparam int DEPTH = 4;
  localparam int CB    = 53;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busData = '0;
  logic       busPar = 1'b1;
  logic       busSoc = 1'b0;
  logic       busEnN = 1'b1;
  logic       cellRoom;
  logic       parChkEn = 1'b0;
  logic [1:0] irqEn = 2'b00;
  logic [1:0] stsClr = 2'b00;
  logic [1:0] sts;
  logic       irq;
  logic       popReady = 1'b0;
  logic       outValid;
  logic [7:0] outData;
  logic       outSoc;

  always #4 clk = ~clk;

  cell_tx_ingress #(.DEPTH_CELLS(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .busData(busData), .busPar(busPar),
    .busSoc(busSoc), .busEnN(busEnN), .cellRoom(cellRoom),
    .parChkEn(parChkEn), .irqEn(irqEn), .stsClr(stsClr), .sts(sts),
    .irq(irq), .popReady(popReady), .outValid(outValid),
    .outData(outData), .outSoc(outSoc)
  );

  int total = 0;
  int bad = 0;
  int cellsOut = 0;
  bit popOn = 1'b0;

  // reference model
  byte unsigned storedQ[$];
  byte unsigned partialQ[$];
  bit           capM = 1'b0;
  bit [1:0]     stsM = 2'b00;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int heldCells();
    return (storedQ.size() + CB - 1) / CB;
  endfunction

  task automatic checkOutputs();
    check(outValid == (storedQ.size() > 0), "R3 outValid", int'(outValid), int'(storedQ.size() > 0));
    if (storedQ.size() > 0 && outValid) begin
      check(outData == storedQ[0], "R9 outData", int'(outData), int'(storedQ[0]));
      check(outSoc == (storedQ.size() % CB == 0), "R9 outSoc", int'(outSoc),
            int'(storedQ.size() % CB == 0));
    end
    check(cellRoom == (heldCells() < DEPTH), "R1 cellRoom", int'(cellRoom), int'(heldCells() < DEPTH));
    check(sts == stsM, "R6 sts", int'(sts), int'(stsM));
    check(irq == |(stsM & irqEn), "R7 irq", int'(irq), int'(|(stsM & irqEn)));
  endtask

  task automatic step(input bit en, input bit soc, input byte unsigned d,
                      input bit parErr, input bit pop, input bit [1:0] clr);
    bit roomNow;
    bit [1:0] setV;
    @(negedge clk);
    checkOutputs();
    busEnN   = !en;
    busSoc   = soc;
    busData  = d;
    busPar   = parErr ? ^d : ~^d;
    popReady = pop;
    stsClr   = clr;
    // model of the coming rising edge
    roomNow = heldCells() < DEPTH;
    setV = 2'b00;
    if (pop && storedQ.size() > 0) begin
      if (storedQ.size() % CB == 0) cellsOut++;
      void'(storedQ.pop_front());
    end
    if (en) begin
      if (parErr && parChkEn) setV[0] = 1'b1;
      if (soc) begin
        if (capM) setV[1] = 1'b1;
        partialQ.delete();
        capM = roomNow;
        if (roomNow) partialQ.push_back(d);
      end else if (capM) begin
        partialQ.push_back(d);
        if (partialQ.size() == CB) begin
          foreach (partialQ[i]) storedQ.push_back(partialQ[i]);
          partialQ.delete();
          capM = 1'b0;
        end
      end
    end
    stsM = (stsM & ~clr) | setV;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0, popOn, 2'b00);
  endtask

  task automatic sendCell(input byte unsigned base, input int len, input int badAt);
    for (int i = 0; i < len; i++)
      step(1'b1, i == 0, byte'(base + i), i == badAt, popOn, 2'b00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    idle(1);
    check(outValid == 1'b0, "R3 reset outValid", int'(outValid), 0);
    check(cellRoom == 1'b1, "R1 reset cellRoom", int'(cellRoom), 1);
    check(sts == 2'b00, "R6 reset sts", int'(sts), 0);

    // R2: bytes with enable high, and stray bytes outside a cell, are ignored
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 2'b00);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'h66, 1'b0, 1'b0, 2'b00);
    idle(1);
    check(outValid == 1'b0, "R2 nothing stored", int'(outValid), 0);

    // R1 and R3: fill the store with pop off
    for (int c = 0; c < DEPTH; c++) begin
      sendCell(byte'(8'h10 * (c + 1)), CB - 1, -1);
      step(1'b1, 1'b0, 8'hEE, 1'b0, 1'b0, 2'b00);
    end
    idle(1);
    check(cellRoom == 1'b0, "R1 store full", int'(cellRoom), 0);
    // R10: a cell offered with no room is discarded
    sendCell(8'hA0, CB, -1);
    popOn = 1'b1;
    cellsOut = 0;
    idle(DEPTH * CB + 5);
    check(cellsOut == DEPTH, "R10 cells drained", cellsOut, DEPTH);
    check(outValid == 1'b0, "R10 store empty", int'(outValid), 0);

    // R8: runt then a full cell
    popOn = 1'b0;
    sendCell(8'h40, 20, -1);
    sendCell(8'h80, CB, -1);
    idle(1);
    check(sts[1] == 1'b1, "R8 runt flagged", int'(sts[1]), 1);
    check(outValid && outSoc && outData == 8'h80, "R8 new cell head", int'(outData), 'h80);
    popOn = 1'b1;
    cellsOut = 0;
    idle(CB + 2);
    check(cellsOut == 1, "R8 one cell kept", cellsOut, 1);
    // R6: clear runt bit
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'b10);
    idle(1);
    check(sts[1] == 1'b0, "R6 cleared", int'(sts[1]), 0);

    // R5: checking off, bad parity passes silently
    parChkEn = 1'b0;
    sendCell(8'h20, CB, 5);
    idle(2);
    check(sts[0] == 1'b0, "R5 no parity record", int'(sts[0]), 0);
    // R4: checking on
    parChkEn = 1'b1;
    sendCell(8'h30, CB, 7);
    idle(1);
    check(sts[0] == 1'b1, "R4 parity recorded", int'(sts[0]), 1);
    irqEn = 2'b00;
    idle(1);
    check(irq == 1'b0, "R7 masked", int'(irq), 0);
    irqEn = 2'b01;
    idle(1);
    check(irq == 1'b1, "R7 enabled", int'(irq), 1);
    // R6: set wins over clear in the same cycle
    step(1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 2'b01);
    idle(1);
    check(sts[0] == 1'b1, "R6 set beats clear", int'(sts[0]), 1);
    idle(CB * 3);

    // constrained random traffic
    begin
      int pos = 0;
      for (int n = 0; n < 4000; n++) begin
        bit en, soc, perr, pop;
        bit [1:0] clr;
        en  = ($urandom % 10) < 8;
        soc = 1'b0;
        if (en) begin
          if (pos == 0 || ($urandom % 70) == 0) begin
            soc = 1'b1;
            pos = 1;
          end else begin
            pos++;
          end
          if (pos >= CB) pos = 0;
        end
        perr = ($urandom % 20) == 0;
        pop  = ($urandom % 10) < 5;
        clr  = (($urandom % 30) == 0) ? 2'($urandom) : 2'b00;
        if (n % 250 == 0) begin
          irqEn    = 2'($urandom);
          parChkEn = 1'($urandom);
        end
        step(en, soc, 8'($urandom), perr, pop, clr);
      end
    end
    popOn = 1'b1;
    idle(DEPTH * CB + 4);
    check(outValid == 1'b0, "R9 final drain", int'(outValid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule